// File: doc/BRIEF.md
# Conditional Trap Comparator

This block decides whether a conditional trap instruction fires. It receives two operands and a five-bit condition mask. A mode select chooses between a 32-bit word comparison and a 64-bit doubleword comparison. Five relations are computed side by side: signed less-than, signed greater-than, equality, unsigned less-than and unsigned greater-than. Each mask bit enables one relation. The trap fires when any enabled relation holds.

The comparison logic is purely combinational. The verdict is captured on a valid input, and a single registered strobe presents it one clock later. A trap carries a fixed program-exception trap sub-code, which the exception entry logic downstream consumes. Instruction decode and exception entry sit outside this block.

The report path is a two-state machine:
- `ST_IDLE`: no verdict is presented.
- `ST_REPORT`: a verdict is presented for one cycle.

Its transitions are named as follows:
- `IDLE_TO_REPORT`: taken on `in_valid`.
- `REPORT_HOLD`: `ST_REPORT` to `ST_REPORT`, taken on back-to-back `in_valid`.
- `REPORT_TO_IDLE`: taken when `in_valid` is low.
- `IDLE_HOLD`: the machine stays idle with no input.

Top module: `trap_compare_unit`

## Requirements
- R1: After reset, `trap_valid`, `trap` and `trap_code` are all 0.
- R2: `trap_valid` is 1 in the cycle after each clock edge that samples `in_valid` high, and 0 in the cycle after any edge that samples it low.
- R3: Condition bit 4 enables a trap when A is less than B as two's-complement signed numbers.
- R4: Condition bit 3 enables a trap when A is greater than B as signed numbers.
- R5: Condition bit 2 enables a trap when A equals B.
- R6: Condition bit 1 enables a trap when A is less than B unsigned. Condition bit 0 enables a trap when A is greater than B unsigned.
- R7: With `dword_mode` = 0, only bits 31:0 of each operand take part, and bit 31 is the sign. Bits 63:32 have no effect.
- R8: With `dword_mode` = 1, all 64 bits take part, and bit 63 is the sign.
- R9: A condition mask of 0 never traps. A mask of 5'h1F always traps.
- R10: `trap` is 1 only together with `trap_valid`. `trap_code` equals 4'h3, the trap sub-code, when `trap` is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and mask are valid this cycle |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| cond | input | 5 | Relation enable mask (bit 4 signed lt, 3 signed gt, 2 eq, 1 unsigned lt, 0 unsigned gt) |
| dword_mode | input | 1 | 1 = 64-bit compare, 0 = 32-bit compare |
| trap_valid | output | 1 | Verdict strobe, one cycle after in_valid |
| trap | output | 1 | Trap request |
| trap_code | output | 4 | Program-exception sub-code, 4'h3 on a trap |

## Verification
The assertions assume that `op_a`, `op_b`, `cond` and `dword_mode` are stable and known whenever `in_valid` is sampled high. They also assume that reset is held for at least one clock edge before the first valid input. The bench changes inputs only on the falling edge and raises `in_valid` only after reset is released. It also drives defined values on every operand bit, including the upper half in word mode, so that the checks that the upper half has no effect rest on real data.

// File: rtl/trap_cmp_pkg.sv
package trap_cmp_pkg;
    localparam int REL_COUNT = 5;

    // Relation vector; bit order matches the condition mask.
    typedef struct packed {
        logic slt;
        logic sgt;
        logic eq;
        logic ult;
        logic ugt;
    } rel_vec_t;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } rpt_state_e;
endpackage

// File: rtl/trap_operand_shaper.sv
module trap_operand_shaper #(
    parameter int XLEN = 64,
    parameter int HALF = XLEN / 2
) (
    input  logic [XLEN-1:0] op,
    input  logic            dword_mode,
    output logic [XLEN:0]   sext,
    output logic [XLEN:0]   zext
);
    localparam int PAD = XLEN - HALF + 1;

    always_comb begin
        if (dword_mode) begin
            sext = {op[XLEN-1], op};
            zext = {1'b0, op};
        end else begin
            sext = {{PAD{op[HALF-1]}}, op[HALF-1:0]};
            zext = {{PAD{1'b0}}, op[HALF-1:0]};
        end
    end
endmodule

// File: rtl/trap_relation_unit.sv
module trap_relation_unit
    import trap_cmp_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN:0] a_s,
    input  logic [XLEN:0] b_s,
    input  logic [XLEN:0] a_u,
    input  logic [XLEN:0] b_u,
    output rel_vec_t      rel
);
    always_comb begin
        rel.slt = $signed(a_s) < $signed(b_s);
        rel.sgt = $signed(a_s) > $signed(b_s);
        rel.eq  = a_u == b_u;
        rel.ult = a_u < b_u;
        rel.ugt = a_u > b_u;
    end
endmodule

// File: rtl/trap_mask_reduce.sv
module trap_mask_reduce
    import trap_cmp_pkg::*;
(
    input  rel_vec_t               rel,
    input  logic [REL_COUNT-1:0]   cond,
    output logic                   hit
);
    logic [REL_COUNT-1:0] rel_bits;
    logic [REL_COUNT-1:0] sel;

    assign rel_bits = rel;

    for (genvar i = 0; i < REL_COUNT; i++) begin : g_sel
        assign sel[i] = cond[i] & rel_bits[i];
    end

    assign hit = |sel;
endmodule

// File: rtl/trap_report_fsm.sv
module trap_report_fsm
    import trap_cmp_pkg::*;
#(
    parameter int          CODE_W    = 4,
    parameter logic [CODE_W-1:0] TRAP_CODE = 4'h3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              hit,
    output logic              trap_valid,
    output logic              trap,
    output logic [CODE_W-1:0] trap_code
);
    rpt_state_e state_q, state_d;
    logic       hit_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = in_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_d = in_valid ? ST_REPORT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hit_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            hit_q   <= in_valid & hit;
        end
    end

    always_comb begin
        trap_valid = 1'b0;
        trap       = 1'b0;
        trap_code  = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_REPORT: begin
                trap_valid = 1'b1;
                trap       = hit_q;
                trap_code  = hit_q ? TRAP_CODE : '0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/trap_compare_unit.sv
module trap_compare_unit
    import trap_cmp_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int CODE_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [XLEN-1:0]      op_a,
    input  logic [XLEN-1:0]      op_b,
    input  logic [REL_COUNT-1:0] cond,
    input  logic                 dword_mode,
    output logic                 trap_valid,
    output logic                 trap,
    output logic [CODE_W-1:0]    trap_code
);
    logic [XLEN:0] a_s, a_u, b_s, b_u;
    rel_vec_t      rel;
    logic          hit;

    trap_operand_shaper #(.XLEN(XLEN)) u_shape_a (
        .op(op_a), .dword_mode(dword_mode), .sext(a_s), .zext(a_u)
    );
    trap_operand_shaper #(.XLEN(XLEN)) u_shape_b (
        .op(op_b), .dword_mode(dword_mode), .sext(b_s), .zext(b_u)
    );

    trap_relation_unit #(.XLEN(XLEN)) u_rel (
        .a_s(a_s), .b_s(b_s), .a_u(a_u), .b_u(b_u), .rel(rel)
    );

    trap_mask_reduce u_mask (
        .rel(rel), .cond(cond), .hit(hit)
    );

    trap_report_fsm #(.CODE_W(CODE_W), .TRAP_CODE(CODE_W'(3))) u_fsm (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hit(hit),
        .trap_valid(trap_valid), .trap(trap), .trap_code(trap_code)
    );
endmodule

// File: rtl/trap_compare_unit_chk.sv
module trap_compare_unit_chk #(
    parameter int XLEN   = 64,
    parameter int CODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [XLEN-1:0]   op_a,
    input logic [XLEN-1:0]   op_b,
    input logic [4:0]        cond,
    input logic              dword_mode,
    input logic              trap_valid,
    input logic              trap,
    input logic [CODE_W-1:0] trap_code
);
    localparam int HALF = XLEN / 2;

    // R2
    strobe_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> trap_valid);
    // R2
    strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !trap_valid);
    // R10
    trap_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> trap_valid);
    // R10
    code_on_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> trap_code == CODE_W'(3));
    // R10
    code_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap |-> trap_code == '0);
    // R9
    mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond == 5'h00) |=> !trap);
    // R9
    mask_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond == 5'h1F) |=> trap);
    // R5
    equal_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cond == 5'h04 &&
         (dword_mode ? (op_a == op_b) : (op_a[HALF-1:0] == op_b[HALF-1:0])))
        |=> trap);
endmodule

bind trap_compare_unit trap_compare_unit_chk #(.XLEN(XLEN), .CODE_W(CODE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .cond(cond), .dword_mode(dword_mode), .trap_valid(trap_valid),
    .trap(trap), .trap_code(trap_code)
);

// File: tb/trap_compare_unit_test.sv
module trap_compare_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [4:0]  cond = '0;
    logic        dword_mode = 1'b0;
    logic        trap_valid, trap;
    logic [3:0]  trap_code;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_compare_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .cond(cond), .dword_mode(dword_mode), .trap_valid(trap_valid),
        .trap(trap), .trap_code(trap_code)
    );

    function automatic logic model(input logic [63:0] a, input logic [63:0] b,
                                   input logic [4:0] c, input logic dw);
        logic signed [63:0] sa, sb;
        logic [63:0] ua, ub;
        if (dw) begin
            sa = a; sb = b; ua = a; ub = b;
        end else begin
            sa = {{32{a[31]}}, a[31:0]}; sb = {{32{b[31]}}, b[31:0]};
            ua = {32'b0, a[31:0]};       ub = {32'b0, b[31:0]};
        end
        return (c[4] && sa < sb) || (c[3] && sa > sb) || (c[2] && ua == ub) ||
               (c[1] && ua < ub) || (c[0] && ua > ub);
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one valid request and check the verdict one cycle later
    task automatic run_one(input string req, input logic [63:0] a, input logic [63:0] b,
                           input logic [4:0] c, input logic dw, input logic exp_trap);
        @(negedge clk);
        in_valid = 1'b1; op_a = a; op_b = b; cond = c; dword_mode = dw;
        @(posedge clk); #1;
        check({req, " valid"}, trap_valid, 1);
        check({req, " trap"}, trap, exp_trap);
        check({req, " model"}, model(a, b, c, dw), exp_trap);
        check({req, " code"}, trap_code, exp_trap ? 4'h3 : 4'h0);
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 1'b0;
        op_a = 64'hDEAD_BEEF_0000_1111; op_b = 64'h0; cond = 5'h1F;
        @(posedge clk); #1;
        check("R2 idle valid", trap_valid, 0);
        check("R10 idle trap", trap, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid", trap_valid, 0);
        check("R1 trap", trap, 0);
        check("R1 code", trap_code, 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R2 no input", trap_valid, 0);
    endtask

    task automatic t_signed();
        run_one("R3 slt hit", 64'hFFFF_FFFF_FFFF_FFFE, 64'd1, 5'h10, 1'b1, 1'b1);
        run_one("R3 slt miss", 64'd5, 64'd1, 5'h10, 1'b1, 1'b0);
        run_one("R4 sgt hit", 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 5'h08, 1'b1, 1'b1);
        run_one("R4 sgt miss", 64'd3, 64'd3, 5'h08, 1'b1, 1'b0);
        go_idle();
    endtask

    task automatic t_equal_unsigned();
        run_one("R5 eq hit", 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 5'h04, 1'b1, 1'b1);
        run_one("R5 eq miss", 64'd7, 64'd8, 5'h04, 1'b1, 1'b0);
        run_one("R6 ult hit", 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 5'h02, 1'b1, 1'b1);
        run_one("R6 ult miss", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'h02, 1'b1, 1'b0);
        run_one("R6 ugt hit", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'h01, 1'b1, 1'b1);
        run_one("R6 ugt miss", 64'd0, 64'd0, 5'h01, 1'b1, 1'b0);
        go_idle();
    endtask

    task automatic t_word_mode();
        run_one("R7 upper ignored eq", 64'hFFFF_FFFF_0000_0005, 64'h0000_0000_0000_0005, 5'h04, 1'b0, 1'b1);
        run_one("R8 upper used eq", 64'hFFFF_FFFF_0000_0005, 64'h0000_0000_0000_0005, 5'h04, 1'b1, 1'b0);
        run_one("R7 bit31 sign slt", 64'h0000_0000_8000_0000, 64'd1, 5'h10, 1'b0, 1'b1);
        run_one("R8 bit31 not sign", 64'h0000_0000_8000_0000, 64'd1, 5'h10, 1'b1, 1'b0);
        run_one("R7 word ugt", 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_0000_0001, 5'h01, 1'b0, 1'b1);
        run_one("R8 dword ugt", 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_0000_0001, 5'h01, 1'b1, 1'b0);
        go_idle();
    endtask

    task automatic t_mask_edges();
        run_one("R9 zero mask eq", 64'd9, 64'd9, 5'h00, 1'b1, 1'b0);
        run_one("R9 zero mask lt", 64'd1, 64'd9, 5'h00, 1'b0, 1'b0);
        run_one("R9 full mask eq", 64'd9, 64'd9, 5'h1F, 1'b1, 1'b1);
        run_one("R9 full mask ne", 64'd2, 64'hFFFF_FFFF_FFFF_FFF0, 5'h1F, 1'b0, 1'b1);
        run_one("R6 mixed sign/unsigned", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'h11, 1'b1, 1'b1);
        go_idle();
    endtask

    task automatic t_strobe();
        run_one("R2 first", 64'd4, 64'd4, 5'h04, 1'b1, 1'b1);
        run_one("R2 back to back", 64'd4, 64'd5, 5'h04, 1'b1, 1'b0);
        go_idle();
        @(posedge clk); #1;
        check("R2 stays low", trap_valid, 0);
        check("R10 no code", trap_code, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_signed();
        t_equal_unsigned();
        t_word_mode();
        t_mask_edges();
        t_strobe();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule